// File: doc/BRIEF.md
# Multi-Block Circular Audio Sample Buffer

This block holds a stream of 16-bit audio samples in on-chip storage. The storage is split into `NUM_BLK` equal blocks of `BLK_LEN` samples each, and the blocks are used in ring order. A producer, normally the receive side of an audio serial port, writes samples one per cycle into the block it currently owns. When the last sample of that block lands, the block is handed over to the consumer as one unit. A one-cycle completion pulse carries the block's number. The very next sample goes to the following block.

The consumer pulls samples one request at a time from the oldest filled block, and in the same ring order. When it has read the last sample of a block, that block becomes free for the producer again. Samples come out in the order they went in. A stereo stream stored left-then-right is therefore read back left-then-right. Each block's full flag can be seen on a status vector.

Two sticky flags record misuse. Overflow is set when the producer tries to write into a block the consumer has not yet freed; those samples are dropped. Underflow is set when the consumer asks for a sample while no block is full; it receives zero. The same block serves a playback path with the roles swapped. With `NUM_BLK` set to 2 it works as a classic ping-pong pair.

Top module: `audio_blk_ring`

## Requirements
- R1: After reset, no block is full, `blk_done`, `rd_valid`, `overflow` and `underflow` are low, and both the write and read pointers sit at block 0, sample 0.
- R2: Samples are read back bit-exact (16 bits) and in exactly the order they were accepted, so the left sample of each interleaved pair is still read before its right sample.
- R3: In the cycle after the last (`BLK_LEN`-th) sample of a block is written, `blk_done` is high for exactly one cycle and `blk_done_idx` gives that block's number; blocks complete in the order 0, 1, …, `NUM_BLK`-1, 0, ….
- R4: A sample written in the cycle right after a block completes is accepted into the next block; back-to-back writes across a block boundary lose nothing.
- R5: Bit i of `blk_full` is high from the cycle after block i completes until the cycle after its last sample is read, and is low otherwise.
- R6: A write made while the block the writer must use is still full is dropped (never read back) and sets `overflow`, which stays high until reset.
- R7: A read request made while no block is full answers with `rd_valid` high and `rd_sample` equal to zero, and sets `underflow`, which stays high until reset.
- R8: Every `rd_req` cycle is answered by `rd_valid` in the next cycle. Reading the last sample of a block frees it, and reading moves on to the next block in ring order.
- R9: With `NUM_BLK` = 2 the two blocks alternate as a ping-pong pair. Completion indices go 0, 1, 0, and a third block's worth of writes overflows until block 0 is freed.
- R10: A write and a read in the same cycle both take effect, so the consumer can drain one block while the producer fills another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe: one sample offered this cycle |
| wr_sample | input | SW (16) | Sample to store |
| rd_req | input | 1 | Read strobe: one sample requested this cycle |
| rd_sample | output | SW (16) | Sample returned one cycle after a request (zero on underflow) |
| rd_valid | output | 1 | `rd_sample` holds the answer to last cycle's request |
| blk_done | output | 1 | One-cycle pulse: a block has just been filled |
| blk_done_idx | output | BW | Number of the block that was just filled |
| blk_full | output | NUM_BLK | Per-block full flags, bit i for block i |
| overflow | output | 1 | Sticky: a write was dropped |
| underflow | output | 1 | Sticky: a read found no full block |

## Verification
The hardest situation to reach is the writer wrapping around onto a block the reader still holds. That happens only after every block in the ring has been filled while the reader has not released the oldest one.

The stimulus gets there by filling `NUM_BLK` whole blocks back to back, partly while draining the first block in the same cycles. It then pushes extra samples into the closed ring, which must be dropped. Draining with idle gaps then shows that none of the dropped samples comes out. A request on the emptied ring returns zero. After the drain, writing resumes at the correct block.

The same sequence is repeated on a two-block instance to cover the ping-pong form.

// File: rtl/rbuf_pkg.sv
`timescale 1ns/1ps
package rbuf_pkg;

  // Advance a block index around a ring of n entries.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Width for an index over n items (never below one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rbuf_mem.sv
`timescale 1ns/1ps
module rbuf_mem #(
  parameter int unsigned NUM_BLK = 3,
  parameter int unsigned BLK_LEN = 16,
  parameter int unsigned SW      = 16,
  parameter int unsigned BW      = 2,
  parameter int unsigned OW      = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [BW-1:0] w_blk,
  input  logic [OW-1:0] w_off,
  input  logic [SW-1:0] w_word,
  input  logic [BW-1:0] r_blk,
  input  logic [OW-1:0] r_off,
  output logic [SW-1:0] r_word
);
  localparam int unsigned DEPTH = NUM_BLK * BLK_LEN;
  localparam int unsigned AW    = rbuf_pkg::idx_w(DEPTH);

  logic [SW-1:0] store_q [DEPTH];
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;

  always_comb begin
    waddr  = AW'(32'(w_blk) * BLK_LEN + 32'(w_off));
    raddr  = AW'(32'(r_blk) * BLK_LEN + 32'(r_off));
    r_word = store_q[raddr];
  end

  // Storage array: write-enabled, no reset.
  always_ff @(posedge clk) begin
    if (we) begin
      store_q[waddr] <= w_word;
    end
  end
endmodule

// File: rtl/rbuf_wr_ctrl.sv
`timescale 1ns/1ps
module rbuf_wr_ctrl #(
  parameter int unsigned NUM_BLK = 3,
  parameter int unsigned BLK_LEN = 16,
  parameter int unsigned BW      = 2,
  parameter int unsigned OW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [NUM_BLK-1:0] full_vec,
  output logic               mem_we,
  output logic [BW-1:0]      wblk,
  output logic [OW-1:0]      woff,
  output logic [NUM_BLK-1:0] set_v,
  output logic               blk_done,
  output logic [BW-1:0]      blk_done_idx,
  output logic               overflow
);
  localparam logic [OW-1:0] LAST_OFF = OW'(BLK_LEN - 1);

  logic [BW-1:0] wblk_q, wblk_d;
  logic [OW-1:0] woff_q, woff_d;
  logic          done_q, done_d;
  logic [BW-1:0] didx_q, didx_d;
  logic          ovf_q, ovf_d;
  logic          cur_full, accept, at_end;

  always_comb begin
    cur_full = full_vec[wblk_q];
    accept   = wr_valid & ~cur_full;
    at_end   = (woff_q == LAST_OFF);
    wblk_d   = wblk_q;
    woff_d   = woff_q;
    done_d   = 1'b0;
    didx_d   = didx_q;
    ovf_d    = ovf_q | (wr_valid & cur_full);
    if (accept) begin
      if (at_end) begin
        woff_d = '0;
        wblk_d = BW'(rbuf_pkg::ring_next(32'(wblk_q), NUM_BLK));
        done_d = 1'b1;
        didx_d = wblk_q;
      end else begin
        woff_d = woff_q + 1'b1;
      end
    end
  end

  for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_set
    assign set_v[gi] = accept & at_end & (wblk_q == BW'(gi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wblk_q <= '0;
      woff_q <= '0;
      done_q <= 1'b0;
      didx_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wblk_q <= wblk_d;
      woff_q <= woff_d;
      done_q <= done_d;
      didx_q <= didx_d;
      ovf_q  <= ovf_d;
    end
  end

  assign mem_we       = accept;
  assign wblk         = wblk_q;
  assign woff         = woff_q;
  assign blk_done     = done_q;
  assign blk_done_idx = didx_q;
  assign overflow     = ovf_q;

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  // R4
  wrap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (woff == '0));
endmodule

// File: rtl/rbuf_rd_ctrl.sv
`timescale 1ns/1ps
module rbuf_rd_ctrl #(
  parameter int unsigned NUM_BLK = 3,
  parameter int unsigned BLK_LEN = 16,
  parameter int unsigned SW      = 16,
  parameter int unsigned BW      = 2,
  parameter int unsigned OW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic [NUM_BLK-1:0] full_vec,
  input  logic [SW-1:0]      r_word,
  output logic [BW-1:0]      rblk,
  output logic [OW-1:0]      roff,
  output logic [NUM_BLK-1:0] clr_v,
  output logic [SW-1:0]      rd_sample,
  output logic               rd_valid,
  output logic               underflow
);
  localparam logic [OW-1:0] LAST_OFF = OW'(BLK_LEN - 1);

  logic [BW-1:0] rblk_q, rblk_d;
  logic [OW-1:0] roff_q, roff_d;
  logic [SW-1:0] data_q, data_d;
  logic          vld_q, vld_d;
  logic          unf_q, unf_d;
  logic          avail, take, at_end;

  always_comb begin
    avail  = full_vec[rblk_q];
    take   = rd_req & avail;
    at_end = (roff_q == LAST_OFF);
    rblk_d = rblk_q;
    roff_d = roff_q;
    vld_d  = rd_req;
    data_d = take ? r_word : '0;
    unf_d  = unf_q | (rd_req & ~avail);
    if (take) begin
      if (at_end) begin
        roff_d = '0;
        rblk_d = BW'(rbuf_pkg::ring_next(32'(rblk_q), NUM_BLK));
      end else begin
        roff_d = roff_q + 1'b1;
      end
    end
  end

  for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_clr
    assign clr_v[gi] = take & at_end & (rblk_q == BW'(gi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rblk_q <= '0;
      roff_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      rblk_q <= rblk_d;
      roff_q <= roff_d;
      vld_q  <= vld_d;
      unf_q  <= unf_d;
      if (rd_req) begin
        data_q <= data_d;
      end
    end
  end

  assign rblk      = rblk_q;
  assign roff      = roff_q;
  assign rd_sample = data_q;
  assign rd_valid  = vld_q;
  assign underflow = unf_q;

  // R8
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R7
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R7
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (full_vec == '0)) |=> (rd_sample == '0));
endmodule

// File: rtl/rbuf_own.sv
`timescale 1ns/1ps
module rbuf_own #(
  parameter int unsigned NUM_BLK = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BLK-1:0] set_v,
  input  logic [NUM_BLK-1:0] clr_v,
  output logic [NUM_BLK-1:0] full_vec
);
  logic [NUM_BLK-1:0] full_q, full_d;

  always_comb begin
    full_d = (full_q | set_v) & ~clr_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
    end else begin
      full_q <= full_d;
    end
  end

  assign full_vec = full_q;

  // R5
  set_clr_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v & clr_v) == '0);

  // R5
  set_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v & full_q) == '0);

  // R5
  clr_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v & ~full_q) == '0);
endmodule

// File: rtl/audio_blk_ring.sv
`timescale 1ns/1ps
module audio_blk_ring #(
  parameter int unsigned NUM_BLK = 3,
  parameter int unsigned BLK_LEN = 16,
  parameter int unsigned SW      = 16,
  localparam int unsigned BW     = rbuf_pkg::idx_w(NUM_BLK),
  localparam int unsigned OW     = rbuf_pkg::idx_w(BLK_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [SW-1:0]      wr_sample,
  input  logic               rd_req,
  output logic [SW-1:0]      rd_sample,
  output logic               rd_valid,
  output logic               blk_done,
  output logic [BW-1:0]      blk_done_idx,
  output logic [NUM_BLK-1:0] blk_full,
  output logic               overflow,
  output logic               underflow
);
  logic               mem_we;
  logic [BW-1:0]      wblk, rblk;
  logic [OW-1:0]      woff, roff;
  logic [SW-1:0]      r_word;
  logic [NUM_BLK-1:0] set_v, clr_v, full_vec;

  rbuf_mem #(.NUM_BLK(NUM_BLK), .BLK_LEN(BLK_LEN), .SW(SW), .BW(BW), .OW(OW)) mem_u (
    .clk(clk), .we(mem_we), .w_blk(wblk), .w_off(woff), .w_word(wr_sample),
    .r_blk(rblk), .r_off(roff), .r_word(r_word)
  );

  rbuf_wr_ctrl #(.NUM_BLK(NUM_BLK), .BLK_LEN(BLK_LEN), .BW(BW), .OW(OW)) wr_u (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .full_vec(full_vec),
    .mem_we(mem_we), .wblk(wblk), .woff(woff), .set_v(set_v),
    .blk_done(blk_done), .blk_done_idx(blk_done_idx), .overflow(overflow)
  );

  rbuf_rd_ctrl #(.NUM_BLK(NUM_BLK), .BLK_LEN(BLK_LEN), .SW(SW), .BW(BW), .OW(OW)) rd_u (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .full_vec(full_vec), .r_word(r_word),
    .rblk(rblk), .roff(roff), .clr_v(clr_v), .rd_sample(rd_sample),
    .rd_valid(rd_valid), .underflow(underflow)
  );

  rbuf_own #(.NUM_BLK(NUM_BLK)) own_u (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .full_vec(full_vec)
  );

  assign blk_full = full_vec;

  // R10
  rw_same_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && full_vec[rblk]) |-> (wblk != rblk));
endmodule

// File: tb/audio_blk_ring_tb_top.sv
`timescale 1ns/1ps
module audio_blk_ring_tb_top;
  logic        clk;
  logic        rst_n;
  logic        sel;
  logic        w_valid;
  logic [15:0] w_data;
  logic        r_req;

  logic [15:0] a_rd, b_rd;
  logic        a_rv, b_rv, a_done, b_done, a_ovf, b_ovf, a_unf, b_unf;
  logic [1:0]  a_idx;
  logic [0:0]  b_idx;
  logic [2:0]  a_full;
  logic [1:0]  b_full;

  audio_blk_ring dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(w_valid & ~sel), .wr_sample(w_data),
    .rd_req(r_req & ~sel), .rd_sample(a_rd), .rd_valid(a_rv), .blk_done(a_done),
    .blk_done_idx(a_idx), .blk_full(a_full), .overflow(a_ovf), .underflow(a_unf)
  );

  audio_blk_ring #(.NUM_BLK(2)) dut2_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(w_valid & sel), .wr_sample(w_data),
    .rd_req(r_req & sel), .rd_sample(b_rd), .rd_valid(b_rv), .blk_done(b_done),
    .blk_done_idx(b_idx), .blk_full(b_full), .overflow(b_ovf), .underflow(b_unf)
  );

  wire [15:0] o_rd   = sel ? b_rd   : a_rd;
  wire        o_rv   = sel ? b_rv   : a_rv;
  wire        o_done = sel ? b_done : a_done;
  wire [1:0]  o_idx  = sel ? {1'b0, b_idx} : a_idx;
  wire [2:0]  o_full = sel ? {1'b0, b_full} : a_full;
  wire        o_ovf  = sel ? b_ovf  : a_ovf;
  wire        o_unf  = sel ? b_unf  : a_unf;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // Reference model state
  int          m_n, m_wblk, m_woff, m_rblk, m_roff, m_cnt;
  bit          m_ovf, m_unf;
  logic [15:0] accq[$];
  logic [15:0] expq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset(input int n);
    m_n = n; m_wblk = 0; m_woff = 0; m_rblk = 0; m_roff = 0; m_cnt = 0;
    m_ovf = 0; m_unf = 0;
    accq.delete();
  endtask

  function automatic logic [2:0] model_mask();
    logic [2:0] mk = '0;
    for (int i = 0; i < m_n; i++) begin
      mk[i] = (((i - m_rblk + m_n) % m_n) < m_cnt);
    end
    return mk;
  endfunction

  function automatic logic [15:0] pat(input int i);
    return {(i % 2 == 0) ? 4'hA : 4'hB, 12'(i)};
  endfunction

  // Driver: one cycle of stimulus, model update, output checks
  task automatic step(input bit wv, input logic [15:0] wd, input bit rr);
    bit acc, take, comp;
    int cidx;
    @(negedge clk);
    w_valid = wv; w_data = wd; r_req = rr;
    acc  = wv && (m_cnt < m_n);
    take = rr && (m_cnt > 0);
    comp = 0; cidx = 0;
    if (rr) expq.push_back(take ? accq[0] : 16'h0);
    if (take) void'(accq.pop_front());
    if (acc) begin
      accq.push_back(wd);
      m_woff++;
      if (m_woff == 16) begin
        m_woff = 0; comp = 1; cidx = m_wblk;
        m_wblk = (m_wblk + 1) % m_n;
        m_cnt++;
      end
    end
    if (take) begin
      m_roff++;
      if (m_roff == 16) begin
        m_roff = 0;
        m_rblk = (m_rblk + 1) % m_n;
        m_cnt--;
      end
    end
    if (wv && !acc) m_ovf = 1;
    if (rr && !take) m_unf = 1;
    @(posedge clk);
    #1;
    w_valid = 0; r_req = 0;
    // R3 (R9 on the two-block instance): completion pulse and index
    chk(o_done == comp, sel ? "R9 blk_done" : "R3 blk_done", o_done, comp);
    if (comp) chk(o_idx == 2'(cidx), sel ? "R9 blk_done_idx" : "R3 blk_done_idx", o_idx, cidx);
    // R6
    chk(o_ovf == m_ovf, "R6 overflow", o_ovf, m_ovf);
    // R7
    chk(o_unf == m_unf, "R7 underflow", o_unf, m_unf);
    // R5
    chk(o_full == model_mask(), "R5 blk_full", o_full, model_mask());
  endtask

  // Monitor: pop expected read results as the design answers
  always @(negedge clk) begin
    if (rst_n && o_rv) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R8 unexpected rd_valid", 1, 0);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        // R2 R4 R7 R10: data order, boundary continuity, zero on empty
        chk(o_rd == e, "R2 R4 R10 rd_sample", o_rd, e);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; sel = 0; w_valid = 0; w_data = '0; r_req = 0;
    model_reset(3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    // R1
    chk(a_full == '0 && b_full == '0, "R1 blk_full", a_full, 0);
    chk(!a_done && !a_rv && !a_ovf && !a_unf, "R1 flags", {a_done, a_rv, a_ovf, a_unf}, 0);
    chk(!b_done && !b_rv && !b_ovf && !b_unf, "R1 flags2", {b_done, b_rv, b_ovf, b_unf}, 0);

    // R7: read on an empty ring
    step(0, '0, 1);
    // R3: fill block 0
    for (int i = 0; i < 16; i++) step(1, pat(i), 0);
    // R10 R4: fill block 1 while draining block 0
    for (int i = 16; i < 32; i++) step(1, pat(i), 1);
    // Fill blocks 2 and 0 back to back
    for (int i = 32; i < 64; i++) step(1, pat(i), 0);
    // R6: ring closed, these are dropped
    for (int i = 64; i < 67; i++) step(1, pat(i), 0);
    // R8: drain with gaps
    for (int i = 0; i < 48; i++) begin
      step(0, '0, 1);
      step(0, '0, 0);
    end
    // R7: empty again
    step(0, '0, 1);
    // R3: writer resumes at block 1
    for (int i = 100; i < 116; i++) step(1, pat(i), 0);
    for (int i = 0; i < 16; i++) step(0, '0, 1);
    step(0, '0, 0);

    // R9: two-block ping-pong instance
    @(negedge clk);
    sel = 1;
    model_reset(2);
    for (int i = 200; i < 232; i++) step(1, pat(i), 0);
    step(1, pat(999), 0);
    for (int i = 0; i < 16; i++) step(0, '0, 1);
    for (int i = 300; i < 316; i++) step(1, pat(i), 0);
    for (int i = 0; i < 32; i++) step(0, '0, 1);
    step(0, '0, 0);
    step(0, '0, 0);

    // R8: every request answered
    chk(expq.size() == 0, "R8 pending reads", expq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule